// File: doc/BRIEF.md
# GMII transmit ordered-set generator

This block sits between a gigabit MAC's byte-wide transmit interface and an 8B/10B encoder. Every clock it turns the enable, error and data inputs into one code-group request for the encoder. A request is an 8-bit value, a control flag and a force-invalid flag. The block tracks whether each code group falls on an even or an odd position. While no frame is in progress it fills the line with two-byte IDLE ordered sets. It marks the start and end of each frame with delimiters. It pads the frame tail so that the IDLEs which follow begin on an even position. It also turns error requests into invalid code groups.

The encoder reports its running disparity back to the block on `disp_pos`, and the block uses this to pick the IDLE variant. The disparity-correcting variant can only be used on the first IDLE of a gap. Start delimiters always go on an even position. When a frame begins on an odd position, the block finishes the current IDLE and then carries the whole frame one byte later, through a one-stage holding register. The block assumes the enable input stays low for at least four cycles between frames.

Top module: `gtx_oset_gen`

## Requirements
- R1: While reset is held, the output is a K28.5 (`cg_data`=0xBC, `cg_k`=1, `cg_inv`=0) with `cg_even`=1. After reset is released, `cg_even` inverts on every clock.
- R2: While no frame is in progress, the output repeats IDLE pairs. The even position carries K28.5 (0xBC, `cg_k`=1). After the first IDLE of a run, the odd position always carries D16.2 (0x50, `cg_k`=0), whatever the value of `disp_pos`.
- R3: The odd byte of the first IDLE after reset, or after a frame, is D5.6 (0xC5) when `disp_pos` is high at that clock edge. Otherwise it is D16.2 (0x50).
- R4: When enable rises on a clock that produces an even position, that clock outputs K27.7 (0xFB, `cg_k`=1) in place of the first byte. The following bytes appear unchanged with `cg_k`=0, one per clock, each on the clock edge that samples it.
- R5: When enable rises on a clock that produces an odd position, that clock completes the IDLE. K27.7 follows on the next (even) clock, and every later byte of the frame comes out one clock later than it was sampled.
- R6: If error is high on the clock where enable rises, a force-invalid request (`cg_inv`=1, `cg_data`=0x00, `cg_k`=0) replaces K27.7. The rest of the frame then passes through as in R4/R5.
- R7: Inside a frame, each byte sampled with error high becomes a force-invalid request, and only those bytes do.
- R8: When enable falls, the next output is K29.7 (0xFD, K), followed by K23.7 (0xF7, K). A second K23.7 is sent only when the first one fell on an even position. The next output is then an even-position K28.5.
- R9: Error has no effect on the output while enable is low: during IDLEs and during the end-of-frame sequence.
- R10: A frame whose preamble is only 0x55 then 0xD5 is accepted: K27.7 is followed by 0xD5 as data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| tx_en | input | 1 | Transmit enable from the MAC |
| tx_er | input | 1 | Transmit error from the MAC |
| txd | input | 8 | Transmit data byte from the MAC |
| disp_pos | input | 1 | Encoder running disparity, high when positive |
| cg_data | output | 8 | Byte value of the requested code group |
| cg_k | output | 1 | Request is a control code group |
| cg_inv | output | 1 | Encoder must emit an invalid code group |
| cg_even | output | 1 | Current request occupies an even position |

## Verification
The case that is hardest to reach from the ports is a frame start on an odd position. It depends on the phase of the free-running even/odd counter at the moment enable rises. The stimulus follows that phase in its own model and holds enable low for an extra cycle whenever it wants a specific alignment. Directed frames use this to cover odd and even starts, false carrier and the two-byte preamble. Random frames then mix frame lengths, so the end delimiter falls on both parities, and they scatter error pulses both inside frames and in the gaps between them.

// File: rtl/gtx_pkg.sv
// Shared constants and types for the GMII transmit ordered-set generator.
// Assumes 8-bit GMII bytes; code-group byte values follow 8B/10B naming.
package gtx_pkg;
    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] CG_K28_5 = 8'hBC;  // comma, even half of IDLE
    localparam logic [BYTE_W-1:0] CG_D5_6  = 8'hC5;  // disparity-flipping IDLE tail
    localparam logic [BYTE_W-1:0] CG_D16_2 = 8'h50;  // disparity-keeping IDLE tail
    localparam logic [BYTE_W-1:0] CG_K27_7 = 8'hFB;  // start delimiter
    localparam logic [BYTE_W-1:0] CG_K29_7 = 8'hFD;  // end delimiter
    localparam logic [BYTE_W-1:0] CG_K23_7 = 8'hF7;  // extend / pad

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_DATA = 2'd1,
        SEQ_PAD1 = 2'd2,
        SEQ_PAD2 = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic              en;
        logic              er;
        logic [BYTE_W-1:0] d;
    } gmii_beat_t;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              k;
        logic              inv;
    } cg_req_t;
endpackage

// File: rtl/gtx_slot_track.sv
// Even/odd position tracker.
// Holds the parity of the code group currently on the output and exposes
// the parity of the one the next clock edge will produce.
// Assumes one code group per clock, never stalled.
module gtx_slot_track #(
    parameter bit RESET_EVEN = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    output logic slot_even,
    output logic next_even
);
    logic even_q;

    // Toggle the position parity every clock; reset places an even slot on the output.
    always_ff @(posedge clk) begin
        if (!rst_n) even_q <= RESET_EVEN;
        else        even_q <= ~even_q;
    end

    assign slot_even = even_q;
    assign next_even = ~even_q;
endmodule

// File: rtl/gtx_skew_buf.sv
// One-beat holding stage for odd-aligned frame starts.
// Registers every incoming GMII beat. When use_held is set, the sequencer
// sees the previous beat instead of the live one, which delays the frame by
// exactly one byte. Assumes use_held changes only at frame boundaries.
module gtx_skew_buf
    import gtx_pkg::*;
#(
    parameter int STAGES = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  gmii_beat_t beat_in,
    input  logic       use_held,
    output gmii_beat_t beat_sel
);
    localparam int LAST = STAGES - 1;

    gmii_beat_t held_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            // Shift the beat history by one position per clock.
            always_ff @(posedge clk) begin
                if (!rst_n)      held_q[s] <= '0;
                else if (s == 0) held_q[s] <= beat_in;
                else             held_q[s] <= held_q[(s == 0) ? 0 : s - 1];
            end
        end
    endgenerate

    // Pick the live beat or the delayed one.
    assign beat_sel = use_held ? held_q[LAST] : beat_in;
endmodule

// File: rtl/gtx_seq_fsm.sv
// Ordered-set sequencer.
// Chooses one code-group request per clock from the frame state, the
// position parity and the encoder's running disparity. Starts frames only
// on even positions, ends them with an end delimiter plus one or two pads,
// and picks the disparity-correcting IDLE only on the first IDLE of a gap.
// Assumes enable stays low for at least four clocks between frames.
module gtx_seq_fsm
    import gtx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  gmii_beat_t beat_sel,
    input  logic       raw_en,
    input  logic       next_even,
    input  logic       slot_even,
    input  logic       disp_pos,
    output logic       lag_o,
    output cg_req_t    cg_o
);
    seq_state_e state_q, state_d;
    logic       first_q, first_d;
    logic       lag_q, lag_d;
    cg_req_t    cg_q, cg_d;

    localparam cg_req_t REQ_IDLE_K = '{data: CG_K28_5, k: 1'b1, inv: 1'b0};
    localparam cg_req_t REQ_SOP    = '{data: CG_K27_7, k: 1'b1, inv: 1'b0};
    localparam cg_req_t REQ_EOP    = '{data: CG_K29_7, k: 1'b1, inv: 1'b0};
    localparam cg_req_t REQ_PAD    = '{data: CG_K23_7, k: 1'b1, inv: 1'b0};
    localparam cg_req_t REQ_BAD    = '{data: '0,       k: 1'b0, inv: 1'b1};

    // Next request and next state from the current frame state.
    always_comb begin
        state_d = state_q;
        first_d = first_q;
        lag_d   = lag_q;
        cg_d    = cg_q;
        unique case (state_q)
            SEQ_IDLE: begin
                if (next_even) begin
                    if (beat_sel.en) begin
                        cg_d    = beat_sel.er ? REQ_BAD : REQ_SOP;
                        state_d = SEQ_DATA;
                        first_d = 1'b1;
                    end else begin
                        cg_d = REQ_IDLE_K;
                    end
                end else begin
                    cg_d.data = (first_q && disp_pos) ? CG_D5_6 : CG_D16_2;
                    cg_d.k    = 1'b0;
                    cg_d.inv  = 1'b0;
                    first_d   = 1'b0;
                    lag_d     = raw_en;
                end
            end
            SEQ_DATA: begin
                if (beat_sel.en) begin
                    if (beat_sel.er) cg_d = REQ_BAD;
                    else             cg_d = '{data: beat_sel.d, k: 1'b0, inv: 1'b0};
                end else begin
                    cg_d    = REQ_EOP;
                    state_d = SEQ_PAD1;
                end
            end
            SEQ_PAD1: begin
                cg_d = REQ_PAD;
                if (next_even) begin
                    state_d = SEQ_PAD2;
                end else begin
                    state_d = SEQ_IDLE;
                    lag_d   = 1'b0;
                    first_d = 1'b1;
                end
            end
            SEQ_PAD2: begin
                cg_d    = REQ_PAD;
                state_d = SEQ_IDLE;
                lag_d   = 1'b0;
                first_d = 1'b1;
            end
            default: begin
                state_d = SEQ_IDLE;
                cg_d    = REQ_IDLE_K;
            end
        endcase
    end

    // Register the request and the sequencing state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            first_q <= 1'b1;
            lag_q   <= 1'b0;
            cg_q    <= REQ_IDLE_K;
        end else begin
            state_q <= state_d;
            first_q <= first_d;
            lag_q   <= lag_d;
            cg_q    <= cg_d;
        end
    end

    assign lag_o = lag_q;
    assign cg_o  = cg_q;

    // R4
    sop_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cg_q.k && cg_q.data == CG_K27_7) |-> slot_even);

    // R2
    comma_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cg_q.k && cg_q.data == CG_K28_5) |-> slot_even);

    // R8
    eop_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cg_q.k && cg_q.data == CG_K29_7) |=> (cg_q.k && cg_q.data == CG_K23_7));

    // R8
    pad_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cg_q.k && cg_q.data == CG_K23_7 && !slot_even) |=>
        (slot_even && (cg_q.inv || (cg_q.k &&
            (cg_q.data == CG_K28_5 || cg_q.data == CG_K27_7)))));

    // R7
    inv_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cg_q.inv |-> !cg_q.k);
endmodule

// File: rtl/gtx_oset_gen.sv
// GMII transmit ordered-set generator, top level.
// Connects the parity tracker, the one-beat holding stage and the sequencer.
// Outputs are registered; the encoder must return its running disparity
// on disp_pos in the same clock it consumes each request.
module gtx_oset_gen
    import gtx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              tx_er,
    input  logic [BYTE_W-1:0] txd,
    input  logic              disp_pos,
    output logic [BYTE_W-1:0] cg_data,
    output logic              cg_k,
    output logic              cg_inv,
    output logic              cg_even
);
    gmii_beat_t beat_raw, beat_sel;
    logic       slot_even, next_even, lag;
    cg_req_t    cg;

    assign beat_raw = '{en: tx_en, er: tx_er, d: txd};

    gtx_slot_track #(.RESET_EVEN(1'b1)) u_slot (
        .clk       (clk),
        .rst_n     (rst_n),
        .slot_even (slot_even),
        .next_even (next_even)
    );

    gtx_skew_buf #(.STAGES(1)) u_skew (
        .clk      (clk),
        .rst_n    (rst_n),
        .beat_in  (beat_raw),
        .use_held (lag),
        .beat_sel (beat_sel)
    );

    gtx_seq_fsm u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .beat_sel  (beat_sel),
        .raw_en    (tx_en),
        .next_even (next_even),
        .slot_even (slot_even),
        .disp_pos  (disp_pos),
        .lag_o     (lag),
        .cg_o      (cg)
    );

    assign cg_data = cg.data;
    assign cg_k    = cg.k;
    assign cg_inv  = cg.inv;
    assign cg_even = slot_even;
endmodule

// File: tb/test_gtx_oset_gen.sv
module test_gtx_oset_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_en = 1'b0, tx_er = 1'b0, disp_pos = 1'b0;
    logic [7:0] txd = 8'h00;
    logic [7:0] cg_data;
    logic       cg_k, cg_inv, cg_even;

    int nvec = 0, nfail = 0;
    bit done = 0;

    // model state
    int         m_st = 0;
    bit         m_even = 1, m_first = 1, m_lag = 0;
    bit         h_en = 0, h_er = 0;
    logic [7:0] h_d = 8'h00;
    logic [7:0] exp_d = 8'hBC;
    bit         exp_k = 1, exp_v = 0;
    string      exp_tag = "R1";
    bit         minpre_mode = 0;

    always #10 clk = ~clk;

    gtx_oset_gen i_gtx_oset_gen (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .tx_er(tx_er), .txd(txd),
        .disp_pos(disp_pos), .cg_data(cg_data), .cg_k(cg_k), .cg_inv(cg_inv),
        .cg_even(cg_even)
    );

    task automatic set_k(input logic [7:0] v, input string t);
        exp_d = v; exp_k = 1; exp_v = 0; exp_tag = t;
    endtask

    task automatic set_d(input logic [7:0] v, input string t);
        exp_d = v; exp_k = 0; exp_v = 0; exp_tag = t;
    endtask

    task automatic set_v(input string t);
        exp_d = 8'h00; exp_k = 0; exp_v = 1; exp_tag = t;
    endtask

    // Expected next output from the requirements, given this cycle's inputs.
    task automatic model_step(input bit en, input bit er, input logic [7:0] d, input bit dp);
        bit ne, s_en, s_er;
        logic [7:0] s_d;
        ne   = !m_even;
        s_en = m_lag ? h_en : en;
        s_er = m_lag ? h_er : er;
        s_d  = m_lag ? h_d  : d;
        case (m_st)
            0: begin
                if (ne) begin
                    if (s_en) begin
                        if (s_er) set_v("R6");
                        else      set_k(8'hFB, m_lag ? "R5" : "R4");
                        m_st = 1; m_first = 1;
                    end else set_k(8'hBC, er ? "R9" : "R2");
                end else begin
                    set_d((m_first && dp) ? 8'hC5 : 8'h50,
                          en ? "R5" : (m_first ? "R3" : (er ? "R9" : "R2")));
                    m_first = 0;
                    m_lag = en;
                end
            end
            1: begin
                if (s_en) begin
                    if (s_er) set_v("R7");
                    else      set_d(s_d, minpre_mode ? "R10" : (m_lag ? "R5" : "R4"));
                end else begin
                    set_k(8'hFD, "R8"); m_st = 2;
                end
            end
            2: begin
                set_k(8'hF7, er ? "R9" : "R8");
                if (ne) m_st = 3;
                else begin m_st = 0; m_lag = 0; m_first = 1; end
            end
            default: begin
                set_k(8'hF7, er ? "R9" : "R8");
                m_st = 0; m_lag = 0; m_first = 1;
            end
        endcase
        h_en = en; h_er = er; h_d = d;
        m_even = ne;
    endtask

    task automatic check_out();
        nvec++;
        if (cg_data !== exp_d || cg_k !== exp_k || cg_inv !== exp_v) begin
            nfail++;
            $display("FAIL %s: got data=%02h k=%0b inv=%0b expected data=%02h k=%0b inv=%0b",
                     exp_tag, cg_data, cg_k, cg_inv, exp_d, exp_k, exp_v);
        end
        if (cg_even !== m_even) begin
            nfail++;
            $display("FAIL R1: got even=%0b expected even=%0b", cg_even, m_even);
        end
    endtask

    task automatic cycle(input bit en, input bit er, input logic [7:0] d, input bit dp);
        tx_en = en; tx_er = er; txd = d; disp_pos = dp;
        model_step(en, er, d, dp);
        @(posedge clk);
        @(negedge clk);
        check_out();
    endtask

    task automatic gap(input int n, input bit noisy);
        for (int i = 0; i < n; i++)
            cycle(1'b0, noisy ? 1'($urandom_range(0, 1)) : 1'b0, 8'($urandom), 1'($urandom_range(0, 1)));
    endtask

    // Frame: pre bytes of preamble (last is D5), then payload; fc = false carrier.
    task automatic send_frame(input int len, input bit odd_start, input bit fc,
                              input int errpos, input int pre, input bit rnd_err);
        while (m_even != odd_start) cycle(1'b0, 1'b0, 8'h00, 1'($urandom_range(0, 1)));
        for (int i = 0; i < len; i++) begin
            logic [7:0] b;
            bit e;
            b = (i < pre - 1) ? 8'h55 : (i == pre - 1) ? 8'hD5 : 8'($urandom);
            e = (i == 0) ? fc : ((i == errpos) || (rnd_err && $urandom_range(0, 19) == 0));
            cycle(1'b1, e, b, 1'($urandom_range(0, 1)));
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    endtask

    initial begin
        #(20 * 200000);
        nfail++;
        $display("FAIL watchdog: got no finish, expected end of stimulus");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5EED_0047));
        // R1 reset state
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check_out();
        end
        rst_n = 1'b1;
        // R3 first IDLE with positive disparity, later ones ignore it (R2)
        cycle(1'b0, 1'b0, 8'h00, 1'b1);
        for (int i = 0; i < 6; i++) cycle(1'b0, 1'b0, 8'h00, 1'b1);
        // R4 even start, R8 endings
        send_frame(10, 1'b0, 1'b0, -1, 8, 1'b0);
        gap(6, 1'b1);                                  // R9 noisy gap
        send_frame(11, 1'b0, 1'b0, -1, 8, 1'b0);
        gap(5, 1'b0);
        // R5 odd start
        send_frame(12, 1'b1, 1'b0, -1, 8, 1'b0);
        gap(4, 1'b1);
        send_frame(9, 1'b1, 1'b0, 4, 8, 1'b0);         // R7 error mid-frame
        gap(4, 1'b0);
        // R6 false carrier on even and odd starts
        send_frame(8, 1'b0, 1'b1, -1, 8, 1'b0);
        gap(4, 1'b0);
        send_frame(8, 1'b1, 1'b1, -1, 8, 1'b0);
        gap(4, 1'b0);
        // R10 minimal preamble
        minpre_mode = 1;
        send_frame(2, 1'b0, 1'b0, -1, 2, 1'b0);
        minpre_mode = 0;
        gap(4, 1'b0);
        // random frames
        for (int f = 0; f < 150; f++) begin
            send_frame($urandom_range(2, 24), 1'($urandom_range(0, 1)), $urandom_range(0, 9) == 0,
                       -1, $urandom_range(2, 8), 1'b1);
            gap($urandom_range(4, 10), 1'($urandom_range(0, 1)));
        end
        finish_run();
    end
endmodule